// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Address-Frame Filtering

This block is a full-duplex asynchronous serial port. It has a transmit side and a receive side. A programmable divider turns the system clock into a sample tick. Each bit lasts 16 ticks, or 8 ticks when the double-speed bit is set.

The transmitter takes bytes through a write strobe. Each byte goes into a one-entry holding buffer. When the shift path is free, the byte moves into the shift path and is sent as a frame:

- a low start bit,
- eight data bits, least significant first,
- an optional ninth bit,
- a high stop bit.

The receiver brings the line into the clock domain with a synchronizer. It confirms a start bit at mid-bit and votes on three samples around the centre of every bit. It then presents the character together with framing-error and overrun flags.

In address-filter mode the receiver keeps only frames whose ninth bit is 1. A host uses this to ignore traffic meant for other stations on a shared line until its own address frame arrives.

Top module: `smp_usart`

## Requirements
- R1: After reset, `tx_pin` is 1, `tx_drive` is 0, `dre` is 1, and `rx_full`, `frame_err` and `overrun` are 0.
- R2: `tx_drive` is 1 while the transmitter is enabled (`ctl[3]`) or still draining. It is 0 otherwise. `tx_pin` is 1 whenever no frame bit is being sent.
- R3: A sample tick occurs every `baud_div`+1 clocks. A transmitted frame is one low start bit, the data bits LSB first, then one high stop bit. Each bit lasts 16 ticks.
- R4: With `ctl[2]` set, every bit lasts 8 ticks, on both the transmit side and the receive side.
- R5: With `nine_bit` set, the frame carries a ninth bit after the eight data bits. Its value is `ctl[0]` as sampled in the cycle of the `wr_stb` write. Later changes to `ctl[0]` do not alter a byte already queued.
- R6: Clearing `ctl[3]` does not stop the transmitter while a byte is in the buffer or in the shift path. Both are sent in full, and `tx_drive` falls only after the last stop bit.
- R7: `dre` is 1 when the holding buffer is empty. A write while `dre` is 0 is ignored: the byte is never sent. A write while `ctl[3]` is 0 is also ignored.
- R8: A received frame with a high stop bit sets `rx_full`, places the data on `rx_byte` and `rx_bit9`, and clears `frame_err`. A `rd_stb` pulse clears `rx_full`.
- R9: A received frame whose stop bit is low sets `frame_err` along with its data.
- R10: A frame that completes while `rx_full` is still 1 sets `overrun` and is dropped: `rx_byte` keeps the earlier value. `rd_stb` clears `overrun`.
- R11: With `ctl[1]` set, frames whose ninth bit is 0 raise no flag and change no output. In 8-bit mode every frame counts as having a ninth bit of 0. The transmitter is not affected by this bit.
- R12: A low pulse on `rx_pin` shorter than half a bit is rejected at the mid-bit check. It raises no flag, and the receiver accepts the next valid frame.
- R13: A `mode_sel` value other than 00 holds the transceiver idle: `tx_drive` is 0, writes are ignored, and the receiver ignores the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Clocks per sample tick, minus one |
| mode_sel | input | 2 | Operating mode; only 00 (asynchronous) is active |
| ctl | input | 4 | [3] transmit enable, [2] double speed, [1] address filter, [0] ninth transmit bit |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| wr_stb | input | 1 | Queue `wr_byte` for transmission |
| wr_byte | input | 8 | Byte to transmit |
| rd_stb | input | 1 | Acknowledge the received character |
| rx_pin | input | 1 | Serial receive line |
| tx_pin | output | 1 | Serial transmit line |
| tx_drive | output | 1 | Transmitter owns the line |
| dre | output | 1 | Holding buffer can accept a byte |
| rx_byte | output | 8 | Received data bits |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_full | output | 1 | Unread character present |
| frame_err | output | 1 | Stop bit of the current character was low |
| overrun | output | 1 | A character was lost while `rx_full` was 1 |

## Verification
The bench targets the following corner cases:

- **Disable while data is queued.** Transmit enable is cleared while one byte is shifting and a second is buffered. A design that honoured the clear at once would drop the drive early and lose the second byte.
- **Ninth bit changed after the write.** The ninth-bit control is changed right after the write. A design that read it at load time would send the wrong address bit.
- **Write into a full buffer.** A third byte is written into a full buffer. A design that accepted it would overwrite the pending byte or send three frames.
- **Receive side.** The bench sends a stop-low frame, a back-to-back overrun pair, a non-address frame in filter mode, and a short start glitch. A design that got these wrong would leave `frame_err` clear, overwrite the unread byte, raise `rx_full` for a foreign frame, or lock onto a false start.

// File: rtl/smp_pkg.sv
package smp_pkg;
   localparam int CB_TXEN = 3;
   localparam int CB_DBL  = 2;
   localparam int CB_MPM  = 1;
   localparam int CB_TX9  = 0;
   localparam logic [1:0] MODE_ASYNC = 2'b00;
   localparam int FR_MAX  = 11;
   localparam int DATA_W  = 8;
endpackage

// File: rtl/smp_tick_gen.sv
module smp_tick_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || tick)   cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/smp_tx.sv
module smp_tx
   import smp_pkg::*;
#(
   parameter int OS_NORM = 16,
   parameter int OS_FAST = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run,
   input  logic              txen,
   input  logic              dbl,
   input  logic              nine,
   input  logic              tx9,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_byte,
   output logic              tx_pin,
   output logic              tx_drive,
   output logic              dre
);
   localparam int SW = $clog2(OS_NORM);

   logic              buf_v;
   logic [DATA_W:0]   buf_d;
   logic              act;
   logic              on;
   logic              len9;
   logic [FR_MAX-1:0] sh;
   logic [SW-1:0]     samp;
   logic [3:0]        bitn;
   logic [SW-1:0]     os_last;
   logic [3:0]        last_idx;
   logic              accept;
   logic              load;

   assign os_last  = dbl ? SW'(OS_FAST - 1) : SW'(OS_NORM - 1);
   assign last_idx = len9 ? 4'd10 : 4'd9;
   assign accept   = run && txen && wr_stb && !buf_v;
   assign load     = run && on && tick && !act && buf_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_v <= 1'b0;
         buf_d <= '0;
         act   <= 1'b0;
         on    <= 1'b0;
         len9  <= 1'b0;
         sh    <= '1;
         samp  <= '0;
         bitn  <= '0;
      end else if (!run) begin
         buf_v <= 1'b0;
         act   <= 1'b0;
         on    <= 1'b0;
         samp  <= '0;
         bitn  <= '0;
      end else begin
         if (accept) begin
            buf_v <= 1'b1;
            buf_d <= {nine & tx9, wr_byte};
         end else if (load) begin
            buf_v <= 1'b0;
         end
         if (load) begin
            sh   <= nine ? {1'b1, buf_d[DATA_W], buf_d[DATA_W-1:0], 1'b0}
                         : {2'b11, buf_d[DATA_W-1:0], 1'b0};
            len9 <= nine;
            act  <= 1'b1;
            samp <= '0;
            bitn <= '0;
         end else if (act && tick) begin
            if (samp == os_last) begin
               samp <= '0;
               if (bitn == last_idx) begin
                  act <= 1'b0;
               end else begin
                  sh   <= {1'b1, sh[FR_MAX-1:1]};
                  bitn <= bitn + 4'd1;
               end
            end else begin
               samp <= samp + 1'b1;
            end
         end
         if (txen)                on <= 1'b1;
         else if (!buf_v && !act) on <= 1'b0;
      end
   end

   assign tx_pin   = (on && act) ? sh[0] : 1'b1;
   assign tx_drive = on;
   assign dre      = !buf_v;

   // R6: drive is kept while data is still queued
   p_drain_keeps_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && on && !txen && (buf_v || act)) |=> tx_drive);

   // R3: a frame opens with a low start bit
   p_start_bit_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (!tx_pin && tx_drive));

   // R7: a write into a full buffer leaves it untouched
   p_full_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && buf_v && !load && wr_stb) |=> (buf_v && $stable(buf_d)));
endmodule

// File: rtl/smp_rx.sv
module smp_rx
   import smp_pkg::*;
#(
   parameter int OS_NORM  = 16,
   parameter int OS_FAST  = 8,
   parameter int SYNC     = 2,
   parameter bit MAJ_VOTE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run,
   input  logic              dbl,
   input  logic              nine,
   input  logic              mpm,
   input  logic              rd_stb,
   input  logic              rx_pin,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_bit9,
   output logic              rx_full,
   output logic              frame_err,
   output logic              overrun
);
   localparam int SW = $clog2(OS_NORM);

   logic [SYNC-1:0] sy;
   logic            rxs;
   logic            busy;
   logic            len9;
   logic [SW-1:0]   samp;
   logic [3:0]      bitn;
   logic [3:0]      bidx;
   logic [1:0]      v;
   logic [DATA_W:0] dbuf;
   logic [SW-1:0]   os_last, h_lo, h_mid, h_hi;
   logic            bit_val;
   logic            eval, is_start, is_stop, fin, keep, fin_keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy <= '1;
      else        sy <= {sy[SYNC-2:0], rx_pin};
   end
   assign rxs = sy[SYNC-1];

   assign os_last = dbl ? SW'(OS_FAST - 1)     : SW'(OS_NORM - 1);
   assign h_lo    = dbl ? SW'(OS_FAST / 2 - 1) : SW'(OS_NORM / 2 - 1);
   assign h_mid   = dbl ? SW'(OS_FAST / 2)     : SW'(OS_NORM / 2);
   assign h_hi    = dbl ? SW'(OS_FAST / 2 + 1) : SW'(OS_NORM / 2 + 1);

   generate
      if (MAJ_VOTE) begin : g_vote
         assign bit_val = (v[0] & v[1]) | (v[0] & rxs) | (v[1] & rxs);
      end else begin : g_centre
         assign bit_val = v[1];
      end
   endgenerate

   assign bidx     = bitn - 4'd1;
   assign eval     = run && tick && busy && (samp == h_hi);
   assign is_start = (bitn == 4'd0);
   assign is_stop  = (bitn == (len9 ? 4'd10 : 4'd9));
   assign fin      = eval && is_stop;
   assign keep     = !mpm || (len9 && dbuf[DATA_W]);
   assign fin_keep = fin && keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         len9 <= 1'b0;
         samp <= '0;
         bitn <= '0;
         v    <= '0;
         dbuf <= '0;
      end else if (!run) begin
         busy <= 1'b0;
         samp <= '0;
         bitn <= '0;
      end else if (tick && !busy) begin
         if (!rxs) begin
            busy <= 1'b1;
            samp <= '0;
            bitn <= '0;
            len9 <= nine;
         end
      end else if (tick && busy) begin
         if (eval && is_start && bit_val) begin
            busy <= 1'b0;
         end else if (fin) begin
            busy <= 1'b0;
         end else begin
            if (samp == h_lo)  v[0] <= rxs;
            if (samp == h_mid) v[1] <= rxs;
            if (eval && !is_start) dbuf[bidx] <= bit_val;
            if (samp == os_last) begin
               samp <= '0;
               bitn <= bitn + 4'd1;
            end else begin
               samp <= samp + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_byte   <= '0;
         rx_bit9   <= 1'b0;
         rx_full   <= 1'b0;
         frame_err <= 1'b0;
         overrun   <= 1'b0;
      end else begin
         if (rd_stb) begin
            rx_full <= 1'b0;
            overrun <= 1'b0;
         end
         if (fin_keep) begin
            if (rx_full && !rd_stb) begin
               overrun <= 1'b1;
            end else begin
               rx_byte   <= dbuf[DATA_W-1:0];
               rx_bit9   <= len9 & dbuf[DATA_W];
               frame_err <= !bit_val;
               rx_full   <= 1'b1;
            end
         end
      end
   end

   // R10: the unread byte survives an overrun
   p_overrun_keeps_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $stable(rx_byte));

   // R11: in filter mode only address frames are delivered
   p_filter_addr_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_full) && $past(mpm)) |-> rx_bit9);

   // R8: a read with no frame landing empties the register
   p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !fin_keep) |=> !rx_full);
endmodule

// File: rtl/smp_usart.sv
module smp_usart
   import smp_pkg::*;
#(
   parameter int DIV_W    = 16,
   parameter int OS_NORM  = 16,
   parameter int OS_FAST  = 8,
   parameter int SYNC     = 2,
   parameter bit MAJ_VOTE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic [1:0]        mode_sel,
   input  logic [3:0]        ctl,
   input  logic              nine_bit,
   input  logic              wr_stb,
   input  logic [7:0]        wr_byte,
   input  logic              rd_stb,
   input  logic              rx_pin,
   output logic              tx_pin,
   output logic              tx_drive,
   output logic              dre,
   output logic [7:0]        rx_byte,
   output logic              rx_bit9,
   output logic              rx_full,
   output logic              frame_err,
   output logic              overrun
);
   generate
      if (OS_NORM != 2 * OS_FAST) begin : g_bad_os
         $error("OS_NORM must be twice OS_FAST");
      end
      if (OS_FAST < 4) begin : g_bad_fast
         $error("OS_FAST must be at least 4 for three-sample voting");
      end
      if (SYNC < 2) begin : g_bad_sync
         $error("SYNC must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be positive");
      end
   endgenerate

   logic run;
   logic tick;

   assign run = (mode_sel == MODE_ASYNC);

   smp_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (baud_div),
      .tick (tick)
   );

   smp_tx #(.OS_NORM(OS_NORM), .OS_FAST(OS_FAST)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .run     (run),
      .txen    (ctl[CB_TXEN]),
      .dbl     (ctl[CB_DBL]),
      .nine    (nine_bit),
      .tx9     (ctl[CB_TX9]),
      .wr_stb  (wr_stb),
      .wr_byte (wr_byte),
      .tx_pin  (tx_pin),
      .tx_drive(tx_drive),
      .dre     (dre)
   );

   smp_rx #(.OS_NORM(OS_NORM), .OS_FAST(OS_FAST), .SYNC(SYNC), .MAJ_VOTE(MAJ_VOTE)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .run      (run),
      .dbl      (ctl[CB_DBL]),
      .nine     (nine_bit),
      .mpm      (ctl[CB_MPM]),
      .rd_stb   (rd_stb),
      .rx_pin   (rx_pin),
      .rx_byte  (rx_byte),
      .rx_bit9  (rx_bit9),
      .rx_full  (rx_full),
      .frame_err(frame_err),
      .overrun  (overrun)
   );
endmodule

// File: tb/test_smp_usart.sv
module test_smp_usart;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] baud_div = 16'd3;
   logic [1:0]  mode_sel = 2'b00;
   logic [3:0]  ctl = 4'b0000;
   logic        nine_bit = 1'b0;
   logic        wr_stb = 1'b0;
   logic [7:0]  wr_byte = 8'h00;
   logic        rd_stb = 1'b0;
   logic        rx_in = 1'b1;
   logic        tx_pin, tx_drive, dre, rx_bit9, rx_full, frame_err, overrun;
   logic [7:0]  rx_byte;

   int n_tests = 0;
   int n_fail  = 0;
   int cur_bp  = 64;
   int got[$];
   int expq[$];

   always #5 clk = ~clk;

   smp_usart i_smp_usart (
      .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .mode_sel(mode_sel),
      .ctl(ctl), .nine_bit(nine_bit), .wr_stb(wr_stb), .wr_byte(wr_byte),
      .rd_stb(rd_stb), .rx_pin(rx_in), .tx_pin(tx_pin), .tx_drive(tx_drive),
      .dre(dre), .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_full(rx_full),
      .frame_err(frame_err), .overrun(overrun)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Behavioural line decoder: frames seen on tx_pin, {stop, ninth, data}
   initial begin
      forever begin
         @(negedge clk);
         if (tx_drive && tx_pin === 1'b0) begin
            int v;
            int nb;
            v  = 0;
            nb = nine_bit ? 9 : 8;
            repeat (cur_bp / 2 - 1) @(negedge clk);
            for (int i = 0; i < nb; i++) begin
               repeat (cur_bp) @(negedge clk);
               v = v | (int'(tx_pin) << i);
            end
            repeat (cur_bp) @(negedge clk);
            v = v | (int'(tx_pin) << 9);
            got.push_back(v);
         end
      end
   end

   task automatic wr(input logic [7:0] b);
      @(negedge clk);
      wr_byte = b;
      wr_stb  = 1'b1;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic rd();
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic wait_got(input int n);
      for (int t = 0; t < 4000 && got.size() < n; t++) @(negedge clk);
   endtask

   task automatic cmp_tx(input string tag);
      check({tag, " frame count"}, got.size(), expq.size());
      for (int i = 0; i < expq.size() && i < got.size(); i++)
         check({tag, " frame"}, got[i], expq[i]);
      got.delete();
      expq.delete();
   endtask

   task automatic send_rx(input int val, input bit n9, input bit stopv, input int bp);
      @(negedge clk);
      rx_in = 1'b0;
      repeat (bp) @(negedge clk);
      for (int i = 0; i < (n9 ? 9 : 8); i++) begin
         rx_in = val[i];
         repeat (bp) @(negedge clk);
      end
      rx_in = stopv;
      repeat (bp) @(negedge clk);
      rx_in = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      bit early;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 tx_pin", tx_pin, 1);
      check("R1 tx_drive", tx_drive, 0);
      check("R1 dre", dre, 1);
      check("R1 rx_full", rx_full, 0);
      check("R1 frame_err", frame_err, 0);
      check("R1 overrun", overrun, 0);

      // R2 enable takes the line
      ctl = 4'b1000;
      repeat (2) @(negedge clk);
      check("R2 drive on enable", tx_drive, 1);
      check("R2 idle line high", tx_pin, 1);

      // R3 8-bit frame at normal speed
      cur_bp = 64;
      wr(8'hA5);
      expq.push_back(32'h2A5);
      wait_got(1);
      repeat (cur_bp) @(negedge clk);
      cmp_tx("R3");

      // R4 double speed transmit
      ctl = 4'b1100;
      cur_bp = 32;
      repeat (cur_bp) @(negedge clk);
      wr(8'h3C);
      expq.push_back(32'h23C);
      wait_got(1);
      repeat (cur_bp) @(negedge clk);
      cmp_tx("R4");

      // R5 ninth bit captured at the write
      ctl = 4'b1001;
      cur_bp = 64;
      nine_bit = 1'b1;
      repeat (cur_bp) @(negedge clk);
      wr(8'h5A);
      ctl = 4'b1000;
      expq.push_back(32'h35A);
      while (!dre) @(negedge clk);
      wr(8'h0F);
      expq.push_back(32'h20F);
      wait_got(2);
      repeat (cur_bp) @(negedge clk);
      cmp_tx("R5");

      // R7 full buffer, then R6 deferred disable
      nine_bit = 1'b0;
      repeat (cur_bp) @(negedge clk);
      wr(8'h11);
      expq.push_back(32'h211);
      while (!dre) @(negedge clk);
      wr(8'h22);
      expq.push_back(32'h222);
      check("R7 dre low when full", dre, 0);
      wr(8'h33);
      check("R7 dre still low", dre, 0);
      ctl = 4'b0000;
      early = 1'b0;
      for (int t = 0; t < 4000 && got.size() < 2; t++) begin
         @(negedge clk);
         if (!tx_drive) early = 1'b1;
      end
      check("R6 drive held while draining", early, 0);
      repeat (cur_bp + 8) @(negedge clk);
      check("R6 drive released after drain", tx_drive, 0);
      repeat (cur_bp * 12) @(negedge clk);
      cmp_tx("R7");

      // R7 write while disabled is ignored
      wr(8'h44);
      check("R7 dre after disabled write", dre, 1);

      // R13 non-async mode holds idle
      ctl = 4'b1000;
      mode_sel = 2'b10;
      repeat (3) @(negedge clk);
      check("R13 no drive", tx_drive, 0);
      wr(8'h77);
      check("R13 write ignored dre", dre, 1);
      send_rx(32'h81, 1'b0, 1'b1, 64);
      check("R13 rx ignored", rx_full, 0);
      mode_sel = 2'b00;
      repeat (cur_bp * 12) @(negedge clk);
      check("R13 nothing sent", got.size(), 0);
      ctl = 4'b0000;
      repeat (4) @(negedge clk);

      // R8 normal receive and read
      send_rx(32'h96, 1'b0, 1'b1, 64);
      check("R8 rx_full", rx_full, 1);
      check("R8 rx_byte", rx_byte, 8'h96);
      check("R8 frame_err clear", frame_err, 0);
      rd();
      check("R8 read clears", rx_full, 0);

      // R9 framing error
      send_rx(32'h5C, 1'b0, 1'b0, 64);
      repeat (128) @(negedge clk);
      check("R9 rx_full", rx_full, 1);
      check("R9 frame_err", frame_err, 1);
      check("R9 rx_byte", rx_byte, 8'h5C);
      rd();

      // R10 overrun
      send_rx(32'h41, 1'b0, 1'b1, 64);
      send_rx(32'h42, 1'b0, 1'b1, 64);
      check("R10 overrun set", overrun, 1);
      check("R10 byte kept", rx_byte, 8'h41);
      rd();
      check("R10 overrun cleared", overrun, 0);

      // R11 address filter
      ctl = 4'b0010;
      nine_bit = 1'b1;
      send_rx(32'h033, 1'b1, 1'b1, 64);
      check("R11 data frame dropped", rx_full, 0);
      send_rx(32'h144, 1'b1, 1'b1, 64);
      check("R11 address frame kept", rx_full, 1);
      check("R11 address byte", rx_byte, 8'h44);
      check("R11 address bit", rx_bit9, 1);
      rd();
      nine_bit = 1'b0;
      send_rx(32'h55, 1'b0, 1'b1, 64);
      check("R11 8-bit frame dropped", rx_full, 0);
      ctl = 4'b0000;

      // R12 start glitch rejection
      @(negedge clk);
      rx_in = 1'b0;
      repeat (6) @(negedge clk);
      rx_in = 1'b1;
      repeat (192) @(negedge clk);
      check("R12 glitch no flag", rx_full, 0);
      send_rx(32'h12, 1'b0, 1'b1, 64);
      check("R12 recovery byte", rx_byte, 8'h12);
      check("R12 recovery flag", rx_full, 1);
      rd();

      // R4 double speed receive
      ctl = 4'b0100;
      repeat (8) @(negedge clk);
      send_rx(32'hC3, 1'b0, 1'b1, 32);
      check("R4 rx double flag", rx_full, 1);
      check("R4 rx double byte", rx_byte, 8'hC3);
      rd();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule